// File: doc/BRIEF.md
# I2C Master Interrupt Status and Mask Logic

This block is the interrupt register set of an I2C master. The transfer core sends it one-cycle pulses for transfer done, NACK, timeout, slave ready and arbitration lost. The block also watches the shared FIFO level, the byte pushes from the core and the host's data reads and writes. From these it raises its own events for the FIFO level threshold, for receive overflow, for transmit overflow and for receive underflow.

Every event is caught in a sticky status register that software clears by writing ones to it. A hidden mask decides which status bits drive the single level-sensitive interrupt line. The mask has no write path of its own. Software sets mask bits through a write-only enable register and clears them through a write-only disable register. The status, mask, enable and disable registers all use the same 10-bit layout. A separate output flags any error-class status bit.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, all mask bits are 0, and `irq` and `err_any` are low.
- R2: The event bit positions are shared by all four registers: 0 done, 1 level threshold, 2 NACK, 3 timeout, 4 slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost. Bit 8 always reads 0. A pulse on a core event input sets its status bit at the next clock edge.
- R3: A status bit that is set stays set until software clears it.
- R4: Writing to register address 0 (status) clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R5: If an event arrives in the same cycle as a clear of its bit, the event wins and the bit stays set.
- R6: Writing to address 2 (enable) sets the mask bits written as 1 and leaves the other mask bits unchanged. Address 2 reads as 0.
- R7: Writing to address 3 (disable) clears the mask bits written as 1 and leaves the other mask bits unchanged. Address 3 reads as 0.
- R8: `irq` is high exactly while some status bit and the matching mask bit are both 1.
- R9: The threshold event (bit 1) fires once, in the cycle in which `fifo_level` becomes DEPTH-2 (14 by default) after holding a different value. While the level stays at 14, the event does not fire again.
- R10: A receive overflow (bit 5) is an `rx_push` while the level equals DEPTH. A transmit overflow (bit 6) is a `host_wr` while the level equals DEPTH. A receive underflow (bit 7) is a `host_rd` while the level is 0. These strobes at any other level raise no event.
- R11: `err_any` is high exactly while any of status bits 2, 5, 6, 7 or 9 is set.
- R12: Address 0 reads the status and address 1 reads the mask. A write to address 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | 5 | Current FIFO fill level, 0..DEPTH |
| rx_push | input | 1 | Core pushes a received byte this cycle |
| host_wr | input | 1 | Host writes a transmit byte this cycle |
| host_rd | input | 1 | Host reads a received byte this cycle |
| ev_done | input | 1 | Transfer complete pulse |
| ev_nack | input | 1 | NACK received pulse |
| ev_timeout | input | 1 | Timeout pulse |
| ev_slv_ready | input | 1 | Slave ready pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 disable |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt output |
| err_any | output | 1 | High while any error-class status bit is set |

## Verification
The assertions assume that `fifo_level` never exceeds DEPTH and that at most one register write happens per cycle. Under that second assumption, an enable and a disable can never hit the mask in the same cycle. The bench drives the level only from the set {0, 13, 14, 15, 16} or from a uniform draw in 0..16. It issues at most one write in each cycle. Core pulses, strobes and writes come from a fixed-seed random source. The bench clears the strobes after every edge, so each pulse lasts exactly one cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_EV = 10;

  localparam int B_DONE   = 0;
  localparam int B_THRESH = 1;
  localparam int B_NACK   = 2;
  localparam int B_TMO    = 3;
  localparam int B_SRDY   = 4;
  localparam int B_RXOVF  = 5;
  localparam int B_TXOVF  = 6;
  localparam int B_RXUNF  = 7;
  localparam int B_ARB    = 9;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_DISABLE = 2'd3
  } reg_sel_e;

  // Bits that count as errors for the summary output.
  function automatic logic [NUM_EV-1:0] err_group_mask();
    logic [NUM_EV-1:0] m;
    m = '0;
    m[B_ARB]   = 1'b1;
    m[B_RXUNF] = 1'b1;
    m[B_TXOVF] = 1'b1;
    m[B_RXOVF] = 1'b1;
    m[B_NACK]  = 1'b1;
    return m;
  endfunction

  // Sticky bit update: an event wins over a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // Mask bit update from separate set and clear strobes.
  function automatic logic mask_next(input logic cur, input logic en, input logic dis);
    return (cur | en) & ~dis;
  endfunction
endpackage

// File: rtl/i2c_irq_events.sv
module i2c_irq_events
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GAP   = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              rx_push,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              ev_done,
  input  logic              ev_nack,
  input  logic              ev_timeout,
  input  logic              ev_slv_ready,
  input  logic              ev_arb_lost,
  output logic [NUM_EV-1:0] ev_vec
);
  localparam logic [LVL_W-1:0] THR_LVL  = LVL_W'(DEPTH - GAP);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_q;
  logic thr_hit;
  logic is_full;
  logic is_empty;
  logic rxovf_hit;
  logic txovf_hit;
  logic rxunf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= fifo_level;
  end

  assign is_full   = (fifo_level == FULL_LVL);
  assign is_empty  = (fifo_level == '0);
  assign thr_hit   = (fifo_level == THR_LVL) && (lvl_q != THR_LVL);
  assign rxovf_hit = rx_push & is_full;
  assign txovf_hit = host_wr & is_full;
  assign rxunf_hit = host_rd & is_empty;

  always_comb begin
    ev_vec           = '0;
    ev_vec[B_DONE]   = ev_done;
    ev_vec[B_THRESH] = thr_hit;
    ev_vec[B_NACK]   = ev_nack;
    ev_vec[B_TMO]    = ev_timeout;
    ev_vec[B_SRDY]   = ev_slv_ready;
    ev_vec[B_RXOVF]  = rxovf_hit;
    ev_vec[B_TXOVF]  = txovf_hit;
    ev_vec[B_RXUNF]  = rxunf_hit;
    ev_vec[B_ARB]    = ev_arb_lost;
  end

  // The threshold event can never fire in two cycles back to back.
  assert_thresh_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> !thr_hit);

  // The level input is assumed never to exceed the FIFO depth.
  assert_level_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FULL_LVL);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_vec,
  input  logic [NUM_EV-1:0] clr_vec,
  output logic [NUM_EV-1:0] status_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= sticky_next(status_q[i], clr_vec[i], set_vec[i]);
    end

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !clr_vec[i]) |=> status_q[i]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status_q[i]);
  end
endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] en_vec,
  input  logic [NUM_EV-1:0] dis_vec,
  output logic [NUM_EV-1:0] mask_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else        mask_q[i] <= mask_next(mask_q[i], en_vec[i], dis_vec[i]);
    end

    assert_enable_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec[i] && !dis_vec[i]) |=> mask_q[i]);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dis_vec[i] |=> !mask_q[i]);

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_vec[i] && !dis_vec[i]) |=> $stable(mask_q[i]));
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GAP   = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              rx_push,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              ev_done,
  input  logic              ev_nack,
  input  logic              ev_timeout,
  input  logic              ev_slv_ready,
  input  logic              ev_arb_lost,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NUM_EV-1:0] reg_wdata,
  output logic [NUM_EV-1:0] reg_rdata,
  output logic              irq,
  output logic              err_any
);
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] clr_vec;
  logic [NUM_EV-1:0] en_vec;
  logic [NUM_EV-1:0] dis_vec;
  logic [NUM_EV-1:0] status_q;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] pending;
  logic wr_status;
  logic wr_enable;
  logic wr_disable;

  assign wr_status  = reg_wr && (reg_addr == SEL_STATUS);
  assign wr_enable  = reg_wr && (reg_addr == SEL_ENABLE);
  assign wr_disable = reg_wr && (reg_addr == SEL_DISABLE);

  assign clr_vec = wr_status  ? reg_wdata : '0;
  assign en_vec  = wr_enable  ? reg_wdata : '0;
  assign dis_vec = wr_disable ? reg_wdata : '0;

  i2c_irq_events #(.DEPTH(DEPTH), .GAP(GAP)) u_events (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_level   (fifo_level),
    .rx_push      (rx_push),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .ev_done      (ev_done),
    .ev_nack      (ev_nack),
    .ev_timeout   (ev_timeout),
    .ev_slv_ready (ev_slv_ready),
    .ev_arb_lost  (ev_arb_lost),
    .ev_vec       (ev_vec)
  );

  i2c_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (ev_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  i2c_irq_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_vec  (en_vec),
    .dis_vec (dis_vec),
    .mask_q  (mask_q)
  );

  assign pending = status_q & mask_q;
  assign irq     = |pending;
  assign err_any = |(status_q & err_group_mask());

  always_comb begin
    unique case (reg_addr)
      SEL_STATUS: reg_rdata = status_q;
      SEL_MASK:   reg_rdata = mask_q;
      default:    reg_rdata = '0;
    endcase
  end

  // With no clear and no disable, an asserted interrupt stays asserted.
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_status && !wr_disable) |=> irq);

  // An event on an enabled bit raises the interrupt at the next edge.
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_vec & mask_q & ~dis_vec)) |=> irq);

  // Only one register strobe of the three can be active at a time.
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_status, wr_enable, wr_disable}) <= 1);

  // The error output follows an error-class event into the status register.
  assert_err_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_vec & err_group_mask())) |=> err_any);
endmodule

// File: tb/sim_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int LW = 5;
  localparam int NE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] fifo_level = '0;
  logic rx_push = 0, host_wr = 0, host_rd = 0;
  logic ev_done = 0, ev_nack = 0, ev_timeout = 0, ev_slv_ready = 0, ev_arb_lost = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [NE-1:0] reg_wdata = '0;
  logic [NE-1:0] reg_rdata;
  logic irq, err_any;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NE-1:0] m_stat = '0;
  logic [NE-1:0] m_mask = '0;
  logic [LW-1:0] m_prev = '0;

  always #10 clk = ~clk;

  i2c_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .rx_push(rx_push),
    .host_wr(host_wr), .host_rd(host_rd), .ev_done(ev_done), .ev_nack(ev_nack),
    .ev_timeout(ev_timeout), .ev_slv_ready(ev_slv_ready), .ev_arb_lost(ev_arb_lost),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .err_any(err_any)
  );

  function automatic logic [NE-1:0] bench_events();
    logic [NE-1:0] e;
    e = '0;
    if (ev_done)      e = e | 10'h001;
    if (fifo_level == 5'd14 && m_prev != 5'd14) e = e | 10'h002;
    if (ev_nack)      e = e | 10'h004;
    if (ev_timeout)   e = e | 10'h008;
    if (ev_slv_ready) e = e | 10'h010;
    if (rx_push && fifo_level == 5'd16) e = e | 10'h020;
    if (host_wr && fifo_level == 5'd16) e = e | 10'h040;
    if (host_rd && fifo_level == 5'd0)  e = e | 10'h080;
    if (ev_arb_lost)  e = e | 10'h200;
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic verify(input string tag);
    reg_wr = 0;
    reg_addr = 2'd0; #1; check({tag, " status"}, 32'(reg_rdata), 32'(m_stat));
    reg_addr = 2'd1; #1; check({tag, " mask"}, 32'(reg_rdata), 32'(m_mask));
    check({tag, " irq R8"}, 32'(irq), 32'(|(m_stat & m_mask)));
    check({tag, " err R11"}, 32'(err_any), 32'(|(m_stat & 10'h2E4)));
  endtask

  task automatic cyc(input string tag);
    logic [NE-1:0] ev, nstat, nmask;
    ev = bench_events();
    nstat = m_stat; nmask = m_mask;
    for (int i = 0; i < NE; i++) begin
      if (ev[i]) nstat[i] = 1'b1;
      else if (reg_wr && reg_addr == 2'd0 && reg_wdata[i]) nstat[i] = 1'b0;
      if (reg_wr && reg_addr == 2'd3 && reg_wdata[i]) nmask[i] = 1'b0;
      else if (reg_wr && reg_addr == 2'd2 && reg_wdata[i]) nmask[i] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    m_stat = nstat; m_mask = nmask; m_prev = fifo_level;
    reg_wr = 0; rx_push = 0; host_wr = 0; host_rd = 0;
    ev_done = 0; ev_nack = 0; ev_timeout = 0; ev_slv_ready = 0; ev_arb_lost = 0;
    verify(tag);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [NE-1:0] d, input string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    fifo_level = 5'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_prev = 5'd5;
    verify("R1 reset");
    reg_addr = 2'd2; #1; check("R6 enable reads 0", 32'(reg_rdata), 0);
    reg_addr = 2'd3; #1; check("R7 disable reads 0", 32'(reg_rdata), 0);

    // R2: every core event lands on its own bit
    ev_done = 1;      cyc("R2 done");     check("R2 bit0", 32'(m_stat), 32'h001);
    ev_nack = 1;      cyc("R2 nack");
    ev_timeout = 1;   cyc("R2 timeout");
    ev_slv_ready = 1; cyc("R2 slvrdy");
    ev_arb_lost = 1;  cyc("R2 arb");      check("R2 layout", 32'(m_stat), 32'h21D);
    repeat (3) cyc("R3 sticky");
    // R4: partial clear
    wreg(2'd0, 10'h005, "R4 partial clear"); check("R4 left", 32'(m_stat), 32'h218);
    wreg(2'd0, 10'h000, "R4 zero write");
    wreg(2'd0, 10'h3FF, "R4 full clear");    check("R4 empty", 32'(m_stat), 0);

    // R9 threshold
    fifo_level = 5'd13; cyc("R9 at13");
    fifo_level = 5'd14; cyc("R9 reach14");   check("R9 fired", 32'(m_stat), 32'h002);
    wreg(2'd0, 10'h002, "R9 clear");
    cyc("R9 hold14");                        check("R9 no refire", 32'(m_stat), 0);
    fifo_level = 5'd15; cyc("R9 at15");
    fifo_level = 5'd14; cyc("R9 back14");    check("R9 refire", 32'(m_stat), 32'h002);
    wreg(2'd0, 10'h3FF, "R9 clr");

    // R10 overflow/underflow
    fifo_level = 5'd15; rx_push = 1; host_wr = 1; cyc("R10 not full");
    check("R10 no event", 32'(m_stat), 0);
    fifo_level = 5'd16; rx_push = 1; cyc("R10 rxovf"); check("R10 bit5", 32'(m_stat), 32'h020);
    host_wr = 1; cyc("R10 txovf");           check("R10 bit6", 32'(m_stat), 32'h060);
    fifo_level = 5'd1; host_rd = 1; cyc("R10 rd nonempty");
    fifo_level = 5'd0; host_rd = 1; cyc("R10 rxunf"); check("R10 bit7", 32'(m_stat), 32'h0E0);
    check("R11 err", 32'(err_any), 1);
    wreg(2'd0, 10'h3FF, "R11 clr");          check("R11 err low", 32'(err_any), 0);

    // R5 event beats clear
    ev_done = 1; cyc("R5 set");
    ev_done = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 10'h001; cyc("R5 collide");
    check("R5 kept", 32'(m_stat), 32'h001);

    // R6/R7/R8 mask and irq
    check("R8 masked", 32'(irq), 0);
    wreg(2'd2, 10'h001, "R6 enable");        check("R8 irq up", 32'(irq), 1);
    wreg(2'd2, 10'h004, "R6 enable more");   check("R6 or", 32'(m_mask), 32'h005);
    wreg(2'd3, 10'h001, "R7 disable");       check("R7 left", 32'(m_mask), 32'h004);
    check("R8 irq down", 32'(irq), 0);
    wreg(2'd1, 10'h3FF, "R12 mask write ignored"); check("R12 mask", 32'(m_mask), 32'h004);
    ev_nack = 1; cyc("R8 nack");             check("R8 irq nack", 32'(irq), 1);
    wreg(2'd0, 10'h004, "R8 clear src");     check("R8 irq cleared", 32'(irq), 0);
    wreg(2'd3, 10'h3FF, "R7 all off");
    wreg(2'd0, 10'h3FF, "R4 all clr");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 6)
        0: fifo_level = 5'd0;
        1: fifo_level = 5'd13;
        2: fifo_level = 5'd14;
        3: fifo_level = 5'd15;
        4: fifo_level = 5'd16;
        default: fifo_level = 5'($urandom % 17);
      endcase
      rx_push = ($urandom % 4) == 0;
      host_wr = ($urandom % 4) == 0;
      host_rd = ($urandom % 4) == 0;
      ev_done = ($urandom % 8) == 0;
      ev_nack = ($urandom % 8) == 0;
      ev_timeout = ($urandom % 8) == 0;
      ev_slv_ready = ($urandom % 8) == 0;
      ev_arb_lost = ($urandom % 8) == 0;
      if (($urandom % 3) == 0) begin
        reg_wr = 1;
        reg_addr = 2'($urandom % 4);
        reg_wdata = 10'($urandom);
      end
      cyc("R3 R4 R6 R7 random");
    end
    finish_run();
  end
endmodule